// File: doc/BRIEF.md
# DMA Source Address Generator

This block keeps the source address of one DMA channel and moves it forward, back, or not at all each time a transfer finishes. The channel controller loads a start address and then strobes a done pulse once per transfer. The block adds or subtracts a step that depends on the transfer size: 1, 2 or 4 bytes, or 16 bytes for a block transfer.

When indirect addressing is on, the register holds a pointer to the memory word that holds the real operand address. In that case the step is always 4, whatever the transfer size. Two settings are not allowed: the reserved mode, and decrement combined with block size. If either is present when a transfer completes, the block raises a sticky error flag and stops moving the address until the next load.

Top module: `dma_src_addr_gen`

## Requirements
- R1: A synchronous active-high `rst` clears `src_addr` and `cfg_err` to zero on the next clock edge.
- R2: When `load` is high, `src_addr` takes `load_addr` and `cfg_err` clears on the next edge. This happens even if `xfer_done` is high in the same cycle.
- R3: With `addr_mode` = 2'b00 (fixed), a done strobe leaves `src_addr` unchanged.
- R4: With `addr_mode` = 2'b01 (increment) and indirect off, a done strobe adds 1, 2, 4 or 16 for `xfer_size` 2'b00, 2'b01, 2'b10 or 2'b11. The new value is visible after the edge that samples the strobe.
- R5: With `addr_mode` = 2'b10 (decrement) and indirect off, a done strobe subtracts 1, 2 or 4 for `xfer_size` 2'b00, 2'b01 or 2'b10.
- R6: With `indirect` high, the step is 4 in increment mode and -4 in decrement mode, for every `xfer_size`.
- R7: A done strobe with `addr_mode` = 2'b11, or with `addr_mode` = 2'b10 and `xfer_size` = 2'b11, sets `cfg_err` and leaves `src_addr` unchanged. This applies whether `indirect` is high or low.
- R8: Once `cfg_err` is set, it stays set and done strobes do not change `src_addr` until a load.
- R9: Address arithmetic wraps modulo 2^32.
- R10: In a cycle with neither `load` nor `xfer_done`, `src_addr` and `cfg_err` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load strobe for a new start address |
| load_addr | input | 32 | Start address to load |
| xfer_done | input | 1 | One transfer finished |
| addr_mode | input | 2 | 00 fixed, 01 increment, 10 decrement, 11 reserved |
| xfer_size | input | 2 | 00 byte, 01 word, 10 longword, 11 16-byte block |
| indirect | input | 1 | Register holds an indirect pointer; step forced to 4 |
| src_addr | output | 32 | Current source address or pointer |
| cfg_err | output | 1 | Sticky flag for an illegal or reserved setting |

## Verification
The assertions check, on every cycle, the behaviours that need no arithmetic model:
- reset clearing the outputs;
- load taking priority over a done strobe;
- the address holding when idle, in fixed mode, on an illegal setting, and while the error flag is set.

The exact step sizes can only be shown by the bench's scenarios. The same holds for the forced step of 4 in indirect mode and for wrap-around at both ends of the address range. The bench compares these against its own model under random and directed stimulus.

// File: rtl/dma_src_addr_gen.sv
`timescale 1ns/1ps
module dma_src_addr_gen #(
  parameter int ADDR_W  = 32,
  parameter int BLK_STEP = 16,
  parameter int PTR_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              xfer_done,
  input  logic [1:0]        addr_mode,
  input  logic [1:0]        xfer_size,
  input  logic              indirect,
  output logic [ADDR_W-1:0] src_addr,
  output logic              cfg_err
);
  localparam logic [ADDR_W-1:0] STEP_B   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_W   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_L   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STEP_BLK = ADDR_W'(BLK_STEP);
  localparam logic [ADDR_W-1:0] STEP_PTR = ADDR_W'(PTR_STEP);

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] next_addr;
  logic              bad_cfg;

  always_comb begin
    if (indirect) step = STEP_PTR;
    else begin
      case (xfer_size)
        2'b00:   step = STEP_B;
        2'b01:   step = STEP_W;
        2'b10:   step = STEP_L;
        default: step = STEP_BLK;
      endcase
    end
  end

  assign bad_cfg = (addr_mode == 2'b11) || (addr_mode == 2'b10 && xfer_size == 2'b11);

  always_comb begin
    case (addr_mode)
      2'b01:   next_addr = src_addr + step;
      2'b10:   next_addr = src_addr - step;
      default: next_addr = src_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_addr <= '0;
      cfg_err  <= 1'b0;
    end else if (load) begin
      src_addr <= load_addr;
      cfg_err  <= 1'b0;
    end else if (xfer_done && !cfg_err) begin
      if (bad_cfg) cfg_err  <= 1'b1;
      else         src_addr <= next_addr;
    end
  end
endmodule

// File: rtl/dma_src_addr_gen_chk.sv
`timescale 1ns/1ps
module dma_src_addr_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic [ADDR_W-1:0] load_addr,
  input logic              xfer_done,
  input logic [1:0]        addr_mode,
  input logic [1:0]        xfer_size,
  input logic [ADDR_W-1:0] src_addr,
  input logic              cfg_err
);
  logic illegal;
  assign illegal = (addr_mode == 2'b11) || (addr_mode == 2'b10 && xfer_size == 2'b11);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (src_addr == '0 && !cfg_err));
  // R2
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (src_addr == $past(load_addr) && !cfg_err));
  // R3
  fixed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && xfer_done && addr_mode == 2'b00) |=> $stable(src_addr));
  // R7
  illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && xfer_done && illegal) |=> (cfg_err && $stable(src_addr)));
  // R8
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && !load) |=> (cfg_err && $stable(src_addr)));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !xfer_done) |=> ($stable(src_addr) && $stable(cfg_err)));
endmodule

bind dma_src_addr_gen dma_src_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .load(load), .load_addr(load_addr), .xfer_done(xfer_done),
  .addr_mode(addr_mode), .xfer_size(xfer_size), .src_addr(src_addr), .cfg_err(cfg_err)
);

// File: tb/test_dma_src_addr_gen.sv
`timescale 1ns/1ps
module test_dma_src_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [31:0] load_addr = '0;
  logic        xfer_done = 1'b0;
  logic [1:0]  addr_mode = '0;
  logic [1:0]  xfer_size = '0;
  logic        indirect = 1'b0;
  logic [31:0] src_addr;
  logic        cfg_err;

  int checks = 0;
  int fails = 0;
  logic [31:0] m_addr = '0;
  logic        m_err = 1'b0;

  always #10 clk = ~clk;

  dma_src_addr_gen i_dma_src_addr_gen (
    .clk(clk), .rst(rst), .load(load), .load_addr(load_addr), .xfer_done(xfer_done),
    .addr_mode(addr_mode), .xfer_size(xfer_size), .indirect(indirect),
    .src_addr(src_addr), .cfg_err(cfg_err)
  );

  function automatic logic [31:0] step_of(logic [1:0] sz, logic ind);
    if (ind) return 32'd4;
    case (sz)
      2'b00: return 32'd1;
      2'b01: return 32'd2;
      2'b10: return 32'd4;
      default: return 32'd16;
    endcase
  endfunction

  function automatic logic is_bad(logic [1:0] md, logic [1:0] sz);
    return (md == 2'b11) || (md == 2'b10 && sz == 2'b11);
  endfunction

  function automatic string req_of(logic ld, logic dn, logic [1:0] md, logic [1:0] sz, logic ind, logic er);
    if (ld) return "R2";
    if (!dn) return "R10";
    if (er) return "R8";
    if (is_bad(md, sz)) return "R7";
    if (md == 2'b00) return "R3";
    if (ind) return "R6";
    if (md == 2'b01) return "R4";
    return "R5";
  endfunction

  task automatic check(string req);
    checks++;
    if (src_addr !== m_addr || cfg_err !== m_err) begin
      fails++;
      $display("FAIL %s: addr=%h err=%b expected addr=%h err=%b", req, src_addr, cfg_err, m_addr, m_err);
    end
  endtask

  task automatic cyc(logic ld, logic [31:0] la, logic dn, logic [1:0] md, logic [1:0] sz, logic ind, string req);
    @(negedge clk);
    load = ld; load_addr = la; xfer_done = dn; addr_mode = md; xfer_size = sz; indirect = ind;
    if (ld) begin m_addr = la; m_err = 1'b0; end
    else if (dn && !m_err) begin
      if (is_bad(md, sz)) m_err = 1'b1;
      else if (md == 2'b01) m_addr = m_addr + step_of(sz, ind);
      else if (md == 2'b10) m_addr = m_addr - step_of(sz, ind);
    end
    @(posedge clk);
    #2;
    check(req);
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(posedge clk); #2;
    m_addr = '0; m_err = 1'b0;
    // R1 reset state after first edge
    check("R1");
    @(negedge clk); rst = 1'b0;
    cyc(1, 32'h1000_0000, 0, 2'b01, 2'b00, 0, "R2");
    cyc(0, 0, 1, 2'b01, 2'b00, 0, "R4");
    cyc(0, 0, 1, 2'b01, 2'b01, 0, "R4");
    cyc(0, 0, 1, 2'b01, 2'b10, 0, "R4");
    cyc(0, 0, 1, 2'b01, 2'b11, 0, "R4");
    cyc(0, 0, 1, 2'b10, 2'b00, 0, "R5");
    cyc(0, 0, 1, 2'b10, 2'b01, 0, "R5");
    cyc(0, 0, 1, 2'b10, 2'b10, 0, "R5");
    cyc(0, 0, 1, 2'b00, 2'b10, 0, "R3");
    cyc(0, 0, 0, 2'b01, 2'b10, 0, "R10");
    cyc(0, 0, 1, 2'b01, 2'b00, 1, "R6");
    cyc(0, 0, 1, 2'b10, 2'b01, 1, "R6");
    cyc(0, 0, 1, 2'b01, 2'b11, 1, "R6");
    cyc(1, 32'hFFFF_FFF8, 0, 2'b00, 2'b00, 0, "R2");
    cyc(0, 0, 1, 2'b01, 2'b11, 0, "R9");
    cyc(1, 32'h0000_0002, 0, 2'b00, 2'b00, 0, "R2");
    cyc(0, 0, 1, 2'b10, 2'b10, 0, "R9");
    cyc(0, 0, 1, 2'b10, 2'b11, 0, "R7");
    cyc(0, 0, 1, 2'b01, 2'b10, 0, "R8");
    cyc(0, 0, 0, 2'b01, 2'b10, 0, "R8");
    cyc(1, 32'h0000_4000, 1, 2'b01, 2'b10, 0, "R2");
    cyc(0, 0, 1, 2'b11, 2'b00, 0, "R7");
    cyc(1, 32'h0000_8000, 0, 2'b00, 2'b00, 0, "R2");
    cyc(0, 0, 1, 2'b10, 2'b11, 1, "R7");
    cyc(1, 32'h0000_9000, 0, 2'b00, 2'b00, 0, "R2");
    for (int i = 0; i < 400; i++) begin
      logic ld, dn, ind;
      logic [1:0] md, sz;
      logic [31:0] la;
      ld = ($urandom % 12) == 0;
      dn = ($urandom % 2) == 1;
      md = 2'($urandom % 3);
      if (($urandom % 20) == 0) md = 2'b11;
      sz = 2'($urandom);
      if (md == 2'b10 && sz == 2'b11 && ($urandom % 4) != 0) sz = 2'b10;
      ind = ($urandom % 4) == 0;
      la = ($urandom % 3 == 0) ? 32'hFFFF_FFF0 + 32'($urandom % 32) : $urandom;
      cyc(ld, la, dn, md, sz, ind, req_of(ld, dn, md, sz, ind, m_err));
    end
    @(negedge clk); rst = 1'b1; load = 0; xfer_done = 0;
    m_addr = '0; m_err = 1'b0;
    @(posedge clk); #2;
    // R1 reset mid-run
    check("R1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule